// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the operand fields of a memory reference into an address. Each request carries a base register value, an index register value, a two-bit scale exponent, a displacement with its encoded width, and an addressing mode. From these the block forms an effective offset. It then adds the base of one of four segment registers, chosen by a default rule or by an explicit override, and produces a linear address.

Two translation styles are supported. In flat style the segment base is added to the full-width offset. In legacy style the offset is cut to 16 bits and the low 16 bits of the segment register, shifted left by four, are added to it. The result is a 20-bit address. Results are registered and appear one clock after the request strobe, and they hold until the next request. The four segment registers are loaded through a simple write port.

Top module: `addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, before any request, `addr_valid`, `lin_addr`, `eff_off` and `seg_used` are all zero.
- R2: `addr_valid` is high in the cycle after a cycle with `req` high, and low in the cycle after a cycle with `req` low.
- R3: The offset depends on `mode` as follows (b = base, x = scaled index, d = extended displacement). 0 gives d. 1 gives b. 2 gives b+d. 3 gives b+index, with no scaling. 4 gives b+index+d, with no scaling. 5 gives b+x. 6 gives b+x+d. 7 gives x+d. All sums wrap modulo 2^AW.
- R4: The scaled index x is index shifted left by `scale`, which gives factors 1, 2, 4 and 8 for `scale` values 0 to 3. The scale has no effect in modes 0 to 4.
- R5: The displacement is sign-extended to AW bits. `disp_size` 0 takes bits 7:0, 1 takes bits 15:0, and 2 or 3 takes bits 31:0.
- R6: With `legacy` low, `eff_off` is the offset and `lin_addr` is the selected segment register plus the offset, modulo 2^AW.
- R7: With `legacy` high, `eff_off` is the offset reduced to its low 16 bits. `lin_addr` is (segment[15:0] × 16 + offset[15:0]) modulo 2^20, and all bits above bit 19 are zero.
- R8: The segment codes are 0 = extra, 1 = code, 2 = stack and 3 = data. `fetch` high selects code. Otherwise `ovr_en` high selects `ovr_sel`. Otherwise the stack segment is used when `base_is_stack` is high and the mode uses a base (modes 1 to 6), and data in every other case. The code in use is reported on `seg_used`.
- R9: `seg_wr_en` loads `seg_wr_data` into the segment register selected by `seg_wr_sel` at the clock edge. A request in the same cycle still uses the value the register had before the write.
- R10: While `req` is low, `lin_addr`, `eff_off` and `seg_used` keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr_en | input | 1 | Segment register write enable |
| seg_wr_sel | input | 2 | Segment register to write |
| seg_wr_data | input | AW | Value written to the segment register |
| req | input | 1 | Address request strobe |
| mode | input | 3 | Addressing mode |
| base | input | AW | Base register value |
| index | input | AW | Index register value |
| scale | input | 2 | Index shift amount |
| disp | input | 32 | Raw displacement |
| disp_size | input | 2 | Displacement width code |
| base_is_stack | input | 1 | Base register is the stack or frame pointer |
| fetch | input | 1 | Request is an instruction fetch |
| ovr_en | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| legacy | input | 1 | 16-bit offset with 20-bit translation |
| addr_valid | output | 1 | Result registered from a request |
| lin_addr | output | AW | Linear address |
| eff_off | output | AW | Effective offset |
| seg_used | output | 2 | Segment code used |

## Verification
The assertions assume that every control input is at a known value at each clock edge while the block is out of reset. They also assume that AW is at least 21 bits wide, so the legacy result fits with zero bits above it. The bench drives every input from the falling edge and keeps AW at its default, so both assumptions always hold. The sweeps cover each mode, scale, displacement width and translation style. They also cover every combination of fetch, override, stack-base flag and mode, and a write to a segment register in the same cycle as a request.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_DISP       = 3'd0,
    AM_REG        = 3'd1,
    AM_REG_D      = 3'd2,
    AM_REG_IDX    = 3'd3,
    AM_REG_IDX_D  = 3'd4,
    AM_REG_SIDX   = 3'd5,
    AM_REG_SIDX_D = 3'd6,
    AM_SIDX_D     = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    SG_EXTRA = 2'd0,
    SG_CODE  = 2'd1,
    SG_STACK = 2'd2,
    SG_DATA  = 2'd3
  } seg_e;

  localparam int NSEG = 4;
  localparam int DISPW = 32;
  localparam int LEG_OFFW = 16;
  localparam int LEG_LINW = 20;

  function automatic logic am_has_base(amode_e m);
    return (m != AM_DISP) && (m != AM_SIDX_D);
  endfunction

  function automatic logic am_has_idx(amode_e m);
    return (m == AM_REG_IDX) || (m == AM_REG_IDX_D) || (m == AM_REG_SIDX) ||
           (m == AM_REG_SIDX_D) || (m == AM_SIDX_D);
  endfunction

  function automatic logic am_has_scale(amode_e m);
    return (m == AM_REG_SIDX) || (m == AM_REG_SIDX_D) || (m == AM_SIDX_D);
  endfunction

  function automatic logic am_has_disp(amode_e m);
    return (m == AM_DISP) || (m == AM_REG_D) || (m == AM_REG_IDX_D) ||
           (m == AM_REG_SIDX_D) || (m == AM_SIDX_D);
  endfunction
endpackage

// File: rtl/agu_offset.sv
module agu_offset
  import agu_pkg::*;
#(
  parameter int AW = 32
) (
  input  amode_e           mode,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    index,
  input  logic [1:0]       scale,
  input  logic [DISPW-1:0] disp,
  input  logic [1:0]       disp_size,
  input  logic             legacy,
  output logic [AW-1:0]    off
);
  logic [DISPW-1:0] d_sized;
  logic [AW-1:0]    d_ext;
  logic [AW-1:0]    t_base;
  logic [AW-1:0]    t_idx;
  logic [AW-1:0]    t_disp;
  logic [AW-1:0]    sum;
  logic [1:0]       shamt;

  always_comb begin
    case (disp_size)
      2'd0:    d_sized = {{(DISPW-8){disp[7]}}, disp[7:0]};
      2'd1:    d_sized = {{(DISPW-16){disp[15]}}, disp[15:0]};
      default: d_sized = disp;
    endcase
    for (int b = 0; b < AW; b++) begin
      d_ext[b] = (b < DISPW) ? d_sized[b] : d_sized[DISPW-1];
    end
  end

  always_comb begin
    shamt  = am_has_scale(mode) ? scale : 2'd0;
    t_base = am_has_base(mode) ? base : '0;
    t_idx  = am_has_idx(mode) ? (index << shamt) : '0;
    t_disp = am_has_disp(mode) ? d_ext : '0;
    sum    = t_base + t_idx + t_disp;
    off    = legacy ? {{(AW-LEG_OFFW){1'b0}}, sum[LEG_OFFW-1:0]} : sum;
  end
endmodule

// File: rtl/agu_segsel.sv
module agu_segsel
  import agu_pkg::*;
(
  input  amode_e     mode,
  input  logic       base_is_stack,
  input  logic       fetch,
  input  logic       ovr_en,
  input  logic [1:0] ovr_sel,
  output seg_e       sel
);
  always_comb begin
    if (fetch) begin
      sel = SG_CODE;
    end else if (ovr_en) begin
      sel = seg_e'(ovr_sel);
    end else if (base_is_stack && am_has_base(mode)) begin
      sel = SG_STACK;
    end else begin
      sel = SG_DATA;
    end
  end
endmodule

// File: rtl/agu_segfile.sv
module agu_segfile
  import agu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  seg_e          rd_sel,
  output logic [AW-1:0] rd_data
);
  logic [AW-1:0] seg_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic          ld;
    logic [AW-1:0] seg_d;

    always_comb begin
      ld    = wr_en && (wr_sel == 2'(g));
      seg_d = ld ? wr_data : seg_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q[g] <= '0;
      else        seg_q[g] <= seg_d;
    end
  end

  assign rd_data = seg_q[rd_sel];
endmodule

// File: rtl/addr_gen.sv
module addr_gen
  import agu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seg_wr_en,
  input  logic [1:0]    seg_wr_sel,
  input  logic [AW-1:0] seg_wr_data,
  input  logic          req,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [1:0]    scale,
  input  logic [31:0]   disp,
  input  logic [1:0]    disp_size,
  input  logic          base_is_stack,
  input  logic          fetch,
  input  logic          ovr_en,
  input  logic [1:0]    ovr_sel,
  input  logic          legacy,
  output logic          addr_valid,
  output logic [AW-1:0] lin_addr,
  output logic [AW-1:0] eff_off,
  output logic [1:0]    seg_used
);
  amode_e        am;
  seg_e          sel;
  logic [AW-1:0] off;
  logic [AW-1:0] segbase;
  logic [AW-1:0] lin_flat;
  logic [LEG_LINW-1:0] lin_leg;
  logic [AW-1:0] lin_c;

  logic          valid_d;
  logic [AW-1:0] lin_d;
  logic [AW-1:0] off_d;
  logic [1:0]    seg_d;

  assign am = amode_e'(mode);

  agu_offset #(.AW(AW)) u_off (
    .mode(am), .base(base), .index(index), .scale(scale),
    .disp(disp), .disp_size(disp_size), .legacy(legacy), .off(off)
  );

  agu_segsel u_sel (
    .mode(am), .base_is_stack(base_is_stack), .fetch(fetch),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel), .sel(sel)
  );

  agu_segfile #(.AW(AW)) u_segs (
    .clk(clk), .rst_n(rst_n), .wr_en(seg_wr_en), .wr_sel(seg_wr_sel),
    .wr_data(seg_wr_data), .rd_sel(sel), .rd_data(segbase)
  );

  always_comb begin
    lin_flat = segbase + off;
    lin_leg  = {segbase[LEG_OFFW-1:0], 4'b0000} +
               {{(LEG_LINW-LEG_OFFW){1'b0}}, off[LEG_OFFW-1:0]};
    lin_c    = legacy ? {{(AW-LEG_LINW){1'b0}}, lin_leg} : lin_flat;
  end

  always_comb begin
    valid_d = req;
    lin_d   = lin_addr;
    off_d   = eff_off;
    seg_d   = seg_used;
    if (req) begin
      lin_d = lin_c;
      off_d = off;
      seg_d = sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      lin_addr   <= '0;
      eff_off    <= '0;
      seg_used   <= 2'd0;
    end else begin
      addr_valid <= valid_d;
      lin_addr   <= lin_d;
      eff_off    <= off_d;
      seg_used   <= seg_d;
    end
  end
endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          fetch,
  input logic          ovr_en,
  input logic [1:0]    ovr_sel,
  input logic          legacy,
  input logic          addr_valid,
  input logic [AW-1:0] lin_addr,
  input logic [AW-1:0] eff_off,
  input logic [1:0]    seg_used
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> addr_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !addr_valid);
  assert_fetch_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && fetch) |=> (seg_used == 2'd1));
  assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !fetch && ovr_en) |=> (seg_used == $past(ovr_sel)));
  assert_leg_lin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && legacy) |=> (lin_addr[AW-1:20] == '0));
  assert_leg_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && legacy) |=> (eff_off[AW-1:16] == '0));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(lin_addr) && $stable(eff_off) && $stable(seg_used)));
endmodule

bind addr_gen addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .fetch(fetch), .ovr_en(ovr_en),
  .ovr_sel(ovr_sel), .legacy(legacy), .addr_valid(addr_valid),
  .lin_addr(lin_addr), .eff_off(eff_off), .seg_used(seg_used)
);

// File: tb/sim_addr_gen.sv
module sim_addr_gen;
  localparam int AW = 32;

  logic          clk;
  logic          rst_n;
  logic          seg_wr_en;
  logic [1:0]    seg_wr_sel;
  logic [AW-1:0] seg_wr_data;
  logic          req;
  logic [2:0]    mode;
  logic [AW-1:0] base;
  logic [AW-1:0] index;
  logic [1:0]    scale;
  logic [31:0]   disp;
  logic [1:0]    disp_size;
  logic          base_is_stack;
  logic          fetch;
  logic          ovr_en;
  logic [1:0]    ovr_sel;
  logic          legacy;
  logic          addr_valid;
  logic [AW-1:0] lin_addr;
  logic [AW-1:0] eff_off;
  logic [1:0]    seg_used;

  int n_run;
  int n_fail;
  bit finished;
  logic [AW-1:0] shadow [4];

  addr_gen #(.AW(AW)) u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [AW-1:0] m_off(logic [2:0] m, logic [AW-1:0] b,
      logic [AW-1:0] x, logic [1:0] s, logic [31:0] d, logic [1:0] ds, logic lg);
    logic [AW-1:0] de, xs, r;
    case (ds)
      2'd0:    de = AW'($signed(d[7:0]));
      2'd1:    de = AW'($signed(d[15:0]));
      default: de = AW'($signed(d));
    endcase
    xs = x * (AW'(1) << s);
    case (m)
      3'd0: r = de;
      3'd1: r = b;
      3'd2: r = b + de;
      3'd3: r = b + x;
      3'd4: r = b + x + de;
      3'd5: r = b + xs;
      3'd6: r = b + xs + de;
      default: r = xs + de;
    endcase
    if (lg) r = r & AW'(32'h0000_FFFF);
    return r;
  endfunction

  function automatic logic [1:0] m_seg(logic f, logic oe, logic [1:0] os,
      logic bs, logic [2:0] m);
    if (f) return 2'd1;
    if (oe) return os;
    if (bs && m != 3'd0 && m != 3'd7) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [AW-1:0] m_lin(logic [AW-1:0] sb, logic [AW-1:0] o, logic lg);
    if (lg) return ((sb & AW'(32'hFFFF)) * 16 + (o & AW'(32'hFFFF))) & AW'(32'hF_FFFF);
    return sb + o;
  endfunction

  task automatic chk(string rq, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr_seg(logic [1:0] s, logic [AW-1:0] v);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = s; seg_wr_data = v;
    @(negedge clk);
    seg_wr_en = 1'b0;
    shadow[s] = v;
  endtask

  task automatic issue(string rq);
    logic [AW-1:0] eo;
    logic [1:0]    es;
    @(negedge clk);
    req = 1'b1;
    eo = m_off(mode, base, index, scale, disp, disp_size, legacy);
    es = m_seg(fetch, ovr_en, ovr_sel, base_is_stack, mode);
    @(posedge clk);
    #1;
    chk({rq, " R2 valid"}, AW'(addr_valid), AW'(1));
    chk({rq, " off"}, eff_off, eo);
    chk({rq, " R8 seg"}, AW'(seg_used), AW'(es));
    chk({rq, " lin"}, lin_addr, m_lin(shadow[es], eo, legacy));
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
    req = 0; mode = 0; base = 0; index = 0; scale = 0; disp = 0;
    disp_size = 0; base_is_stack = 0; fetch = 0; ovr_en = 0; ovr_sel = 0;
    legacy = 0;
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid in reset", AW'(addr_valid), AW'(0));
    chk("R1 lin in reset", lin_addr, '0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 valid after reset", AW'(addr_valid), AW'(0));
    chk("R1 off after reset", eff_off, '0);
    chk("R1 seg after reset", AW'(seg_used), AW'(0));

    wr_seg(2'd0, 32'h1000_0100);
    wr_seg(2'd1, 32'h0000_F000);
    wr_seg(2'd2, 32'h0002_2000);
    wr_seg(2'd3, 32'hABCD_FFF0);

    // R3 R4 R5 R6 R7: modes x scales x displacement widths x translation style
    for (int v = 0; v < 2; v++) begin
      for (int lg = 0; lg < 2; lg++) begin
        for (int m = 0; m < 8; m++) begin
          for (int s = 0; s < 4; s++) begin
            for (int ds = 0; ds < 3; ds++) begin
              mode = 3'(m); scale = 2'(s); disp_size = 2'(ds); legacy = lg[0];
              base  = v == 0 ? 32'h1234_5678 : 32'h0000_FFF0;
              index = v == 0 ? 32'h0000_0F10 : 32'h8000_0003;
              disp  = v == 0 ? 32'hFFFF_FF80 : 32'h0000_7F7F;
              issue(lg != 0 ? "R3 R4 R5 R7 sweep" : "R3 R4 R5 R6 sweep");
            end
          end
        end
      end
    end

    // R8: segment selection over every control combination
    legacy = 1'b0; base = 32'h40; index = 32'h4; disp = 32'h10; disp_size = 2'd0;
    for (int f = 0; f < 2; f++)
      for (int oe = 0; oe < 2; oe++)
        for (int os = 0; os < 4; os++)
          for (int bs = 0; bs < 2; bs++)
            for (int m = 0; m < 8; m++) begin
              fetch = f[0]; ovr_en = oe[0]; ovr_sel = 2'(os);
              base_is_stack = bs[0]; mode = 3'(m);
              issue("R8 select");
            end
    fetch = 0; ovr_en = 0; base_is_stack = 0;

    // R9: write in the same cycle as a request uses the old value
    mode = 3'd1; base = 32'h100;
    @(negedge clk);
    req = 1'b1; seg_wr_en = 1'b1; seg_wr_sel = 2'd3; seg_wr_data = 32'h0555_0000;
    @(posedge clk); #1;
    chk("R9 old segment used", lin_addr, shadow[3] + 32'h100);
    @(negedge clk);
    req = 1'b0; seg_wr_en = 1'b0; shadow[3] = 32'h0555_0000;
    issue("R9 new segment used");
    chk("R9 new value", lin_addr, 32'h0555_0100);

    // R10 and R2: outputs hold while req is low
    begin
      logic [AW-1:0] hl, ho;
      logic [1:0] hs;
      hl = lin_addr; ho = eff_off; hs = seg_used;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        mode = 3'(k); base = base + 32'h333; fetch = k[0]; legacy = k[1];
        @(posedge clk); #1;
        chk("R2 valid low", AW'(addr_valid), AW'(0));
        chk("R10 lin held", lin_addr, hl);
        chk("R10 off held", eff_off, ho);
        chk("R10 seg held", AW'(seg_used), AW'(hs));
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule